// File: doc/BRIEF.md
# Multiplexed-Bus Synchronous PSRAM Burst Writer

This block turns internal write requests into synchronous burst write cycles for an external PSRAM or NOR device whose 16-bit data pins carry both the low address half and the write data. An internal request supplies a 26-bit word address and a burst length. Write words with byte enables are then taken one per beat through a take strobe. The block produces the memory clock at half the system clock rate. It drives chip select, the address-valid strobe, the dedicated upper address pins, the shared address/data bus with its output enable, write enable, output enable and the two byte-lane enables. It also samples the memory's wait input.

An access runs in memory clock cycles. Chip select falls one cycle before the address phase. In the address phase the low address half is on the shared bus while the valid strobe is low. The bus is then released for a programmable latency of `cfg_lat_i + 1` cycles, after which the data beats follow on consecutive cycles. The memory can stretch a beat by pulling wait low. One cycle after the final beat is accepted the bus is released, and chip select rises one cycle later. All pin changes happen on the falling memory clock edge, so the device samples at the rising edge with half a cycle of margin.

Top module: `psram_mux_wr_seq`

## Requirements
- R1: While the sequencer is idle or in reset, chip select, address-valid, write enable, output enable and both byte-lane enables are high, the shared bus is not driven (`mem_ad_oe_o` low), and in reset the memory clock is low.
- R2: `mem_clk_o` toggles on every system clock edge, and no memory pin changes while `mem_clk_o` is high.
- R3: A request is taken in the system clock cycle where `req_ready_o` is high. Chip select is low for exactly one memory cycle before the address phase, and it was high in the cycle before that.
- R4: The address phase lasts one memory cycle, with `mem_adv_n_o` low and the bus driven with address bits [15:0]. Bits [25:16] appear on `mem_ahi_o` and stay unchanged while chip select is low.
- R5: Between the address phase and the first data beat there are exactly `cfg_lat_i + 1` memory cycles (value captured when the request is taken). In those cycles the bus is released and write enable stays low.
- R6: `req_len_i` encodes the beat count minus one. Beats occupy consecutive memory cycles with the bus driven by the words in the order taken. `mem_bl_n_o[0]` is the inverse of `wr_be_i[0]` (lower byte, bus bits 7:0) and `mem_bl_n_o[1]` is the inverse of `wr_be_i[1]` (bits 15:8). `wr_take_o` takes one word per beat.
- R7: `mem_wait_n_i` is active low and sampled at the rising memory clock edge. A beat during which it is sampled low is not accepted and the same word and byte enables repeat in the next cycle.
- R8: Output enable is high at all times. Write enable is low from the address phase through the last beat.
- R9: In the memory cycle after the last accepted beat, chip select is still low, the bus is released and write enable is high. Chip select is high in the cycle after that.
- R10: `done_o` is high for exactly one system clock cycle per burst, while `mem_clk_o` is high during the final beat when that beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_lat_i | input | 4 | Data latency setting, gap is value+1 memory cycles |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Request taken at this clock edge |
| req_addr_i | input | 26 | Word address of the burst |
| req_len_i | input | 4 | Beats in the burst minus one |
| wr_take_o | output | 1 | Current write word is consumed at this edge |
| wr_data_i | input | 16 | Write word on offer |
| wr_be_i | input | 2 | Byte enables of the word on offer |
| done_o | output | 1 | Final beat accepted |
| mem_clk_o | output | 1 | Memory clock |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_adv_n_o | output | 1 | Address valid strobe, active low |
| mem_ahi_o | output | 10 | Upper address bits [25:16] |
| mem_ad_o | output | 16 | Shared address/data bus value |
| mem_ad_oe_o | output | 1 | Drive enable for the shared bus |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_bl_n_o | output | 2 | Byte-lane enables, active low |
| mem_wait_n_i | input | 1 | Wait from memory, active low |

## Verification
The bench targets the latency boundaries: zero, which gives one idle bus cycle, and the maximum of fifteen. An off-by-one counter would show up as a data beat one cycle early or late against the address phase. It runs single-beat and sixteen-beat bursts to catch a beat counter that stops short, overruns or raises done on the wrong beat. It also runs wait patterns, including waits on the final beat. A design that ignored wait would advance to the next word, drop a beat or pulse done too early. Back-to-back requests check that chip select really goes high between accesses and that the upper address stays unchanged throughout each one.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSEL,
    ST_ADDR,
    ST_LAT,
    ST_DATA,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/psram_clk_phase.sv
module psram_clk_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mem_wait_n_i,
  output logic mem_clk_o,
  output logic tick_o,
  output logic wait_ok_o
);
  logic ph_q, ph_d;
  logic wait_q, wait_d;
  logic rise_en;

  // rise_en marks the edge on which the memory clock goes high
  always_comb begin
    ph_d    = ~ph_q;
    rise_en = ~ph_q;
    wait_d  = mem_wait_n_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ph_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wait_q <= 1'b1;
    else if (rise_en) wait_q <= wait_d;
  end

  assign mem_clk_o = ph_q;
  assign tick_o    = ph_q;   // next edge is the falling memory clock edge
  assign wait_ok_o = wait_q;
endmodule

// File: rtl/psram_wr_fsm.sv
module psram_wr_fsm
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int LAT_W  = 4,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wait_ok_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [LAT_W-1:0]  cfg_lat_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  output seq_state_e        state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] word_o,
  output logic [BE_W-1:0]   be_o,
  output logic              req_ready_o,
  output logic              wr_take_o,
  output logic              done_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic [LAT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic [BE_W-1:0]   be_q, be_d;
  logic              fetch;
  logic              last;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    left_d  = left_q;
    lat_d   = lat_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    be_d    = be_q;
    fetch   = 1'b0;
    last    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          state_d = ST_CSEL;
          addr_d  = req_addr_i;
          left_d  = req_len_i;
          lat_d   = cfg_lat_i;
        end
      end
      ST_CSEL: state_d = ST_ADDR;
      ST_ADDR: begin
        state_d = ST_LAT;
        cnt_d   = lat_q;
      end
      ST_LAT: begin
        if (cnt_q == '0) begin
          state_d = ST_DATA;
          fetch   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_DATA: begin
        if (wait_ok_i) begin
          if (left_q == '0) begin
            last    = 1'b1;
            state_d = ST_TAIL;
          end else begin
            left_d = left_q - 1'b1;
            fetch  = 1'b1;
          end
        end
      end
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (fetch) begin
      word_d = wr_data_i;
      be_d   = wr_be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      lat_q   <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      be_q    <= '0;
    end else if (tick_i) begin
      state_q <= state_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      lat_q   <= lat_d;
      cnt_q   <= cnt_d;
      word_q  <= word_d;
      be_q    <= be_d;
    end
  end

  assign state_o     = state_q;
  assign addr_o      = addr_q;
  assign word_o      = word_q;
  assign be_o        = be_q;
  assign req_ready_o = tick_i && (state_q == ST_IDLE);
  assign wr_take_o   = tick_i && fetch;
  assign done_o      = tick_i && last;
endmodule

// File: rtl/psram_pin_drive.sv
module psram_pin_drive
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              cs_n_o,
  output logic              adv_n_o,
  output logic [HI_W-1:0]   ahi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [BE_W-1:0]   bl_n_o
);
  logic in_addr, in_data, in_lat;

  always_comb begin
    in_addr = (state_i == ST_ADDR);
    in_data = (state_i == ST_DATA);
    in_lat  = (state_i == ST_LAT);
    cs_n_o  = (state_i == ST_IDLE);
    adv_n_o = ~in_addr;
    ad_oe_o = in_addr | in_data;
    we_n_o  = ~(in_addr | in_lat | in_data);
    oe_n_o  = 1'b1;
    ahi_o   = addr_i[ADDR_W-1:DATA_W];
    ad_o    = '0;
    if (in_addr)      ad_o = addr_i[DATA_W-1:0];
    else if (in_data) ad_o = word_i;
  end

  generate
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign bl_n_o[g] = ~(in_data & be_i[g]);
    end
  endgenerate
endmodule

// File: rtl/psram_mux_wr_seq.sv
module psram_mux_wr_seq
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int LAT_W  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LAT_W-1:0]  cfg_lat_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              wr_take_o,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  output logic              done_o,
  output logic              mem_clk_o,
  output logic              mem_cs_n_o,
  output logic              mem_adv_n_o,
  output logic [HI_W-1:0]   mem_ahi_o,
  output logic [DATA_W-1:0] mem_ad_o,
  output logic              mem_ad_oe_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [BE_W-1:0]   mem_bl_n_o,
  input  logic              mem_wait_n_i
);
  logic              rst_n;
  logic              tick;
  logic              wait_ok;
  seq_state_e        state;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] word;
  logic [BE_W-1:0]   be;

  psram_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  psram_clk_phase u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .mem_wait_n_i (mem_wait_n_i),
    .mem_clk_o    (mem_clk_o),
    .tick_o       (tick),
    .wait_ok_o    (wait_ok)
  );

  psram_wr_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .LAT_W  (LAT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .wait_ok_i   (wait_ok),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .cfg_lat_i   (cfg_lat_i),
    .wr_data_i   (wr_data_i),
    .wr_be_i     (wr_be_i),
    .state_o     (state),
    .addr_o      (addr),
    .word_o      (word),
    .be_o        (be),
    .req_ready_o (req_ready_o),
    .wr_take_o   (wr_take_o),
    .done_o      (done_o)
  );

  psram_pin_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .state_i (state),
    .addr_i  (addr),
    .word_i  (word),
    .be_i    (be),
    .cs_n_o  (mem_cs_n_o),
    .adv_n_o (mem_adv_n_o),
    .ahi_o   (mem_ahi_o),
    .ad_o    (mem_ad_o),
    .ad_oe_o (mem_ad_oe_o),
    .we_n_o  (mem_we_n_o),
    .oe_n_o  (mem_oe_n_o),
    .bl_n_o  (mem_bl_n_o)
  );
endmodule

// File: rtl/psram_mux_wr_seq_chk.sv
module psram_mux_wr_seq_chk #(
  parameter int HI_W   = 10,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_clk_o,
  input logic              mem_cs_n_o,
  input logic              mem_adv_n_o,
  input logic [HI_W-1:0]   mem_ahi_o,
  input logic [DATA_W-1:0] mem_ad_o,
  input logic              mem_ad_oe_o,
  input logic              mem_we_n_o,
  input logic              done_o
);
  assert_adv_drives_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_n_o |-> (!mem_cs_n_o && mem_ad_oe_o));

  assert_bus_only_selected_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ad_oe_o |-> !mem_cs_n_o);

  assert_upper_addr_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_n_o && !$past(mem_cs_n_o)) |-> $stable(mem_ahi_o));

  assert_pins_still_high_clk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_clk_o |-> ($stable(mem_ad_o) && $stable(mem_ad_oe_o) &&
                   $stable(mem_cs_n_o) && $stable(mem_adv_n_o) && $stable(mem_we_n_o)));

  assert_done_one_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_we_inside_select_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> !mem_cs_n_o);
endmodule

bind psram_mux_wr_seq psram_mux_wr_seq_chk #(
  .HI_W   (HI_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_clk_o   (mem_clk_o),
  .mem_cs_n_o  (mem_cs_n_o),
  .mem_adv_n_o (mem_adv_n_o),
  .mem_ahi_o   (mem_ahi_o),
  .mem_ad_o    (mem_ad_o),
  .mem_ad_oe_o (mem_ad_oe_o),
  .mem_we_n_o  (mem_we_n_o),
  .done_o      (done_o)
);

// File: tb/psram_mux_wr_seq_tb_top.sv
`timescale 1ns/1ps
module psram_mux_wr_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [3:0]  cfg_lat_i;
  logic        req_valid_i;
  logic        req_ready_o;
  logic [25:0] req_addr_i;
  logic [3:0]  req_len_i;
  logic        wr_take_o;
  logic [15:0] wr_data_i;
  logic [1:0]  wr_be_i;
  logic        done_o;
  logic        mem_clk_o, mem_cs_n_o, mem_adv_n_o, mem_ad_oe_o, mem_we_n_o, mem_oe_n_o;
  logic [9:0]  mem_ahi_o;
  logic [15:0] mem_ad_o;
  logic [1:0]  mem_bl_n_o;
  logic        mem_wait_n_i;

  always #10 clk_i = ~clk_i;

  psram_mux_wr_seq dut_i (.*);

  typedef struct { logic [25:0] a; int len; int lat; } rq_t;
  typedef struct { logic [15:0] w; logic [1:0] be; } wd_t;
  rq_t rq_q[$];
  wd_t exp_q[$];
  wd_t feed_q[$];

  int checks = 0, fails = 0;
  int bursts = 0, done_cnt = 0;
  int wait_mode = 0, wcnt = 0;
  bit rst_done = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // driver: pushes expected items, then hands the request over
  task automatic send(input logic [25:0] a, input int n, input int lat);
    rq_t r;
    r.a = a; r.len = n; r.lat = lat;
    for (int i = 0; i < n; i++) begin
      wd_t d;
      d.w  = a[15:0] ^ 16'(i * 16'h1357) ^ 16'(n << 8);
      d.be = 2'(i + n);
      exp_q.push_back(d);
      feed_q.push_back(d);
    end
    rq_q.push_back(r);
    bursts++;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    req_len_i   = 4'(n - 1);
    cfg_lat_i   = 4'(lat);
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // word supply
  bit took = 0;
  always @(negedge clk_i) begin
    if (took) void'(feed_q.pop_front());
    if (feed_q.size() > 0) begin
      wr_data_i = feed_q[0].w;
      wr_be_i   = feed_q[0].be;
    end else begin
      wr_data_i = '0;
      wr_be_i   = '0;
    end
    took = (feed_q.size() > 0) && wr_take_o;
  end

  // wait pattern, changed only while the memory clock is low
  always @(negedge clk_i) begin
    if (!mem_clk_o) begin
      wcnt++;
      case (wait_mode)
        1:       mem_wait_n_i = ((wcnt % 3) != 1);
        2:       mem_wait_n_i = ((wcnt % 7) >= 3);
        default: mem_wait_n_i = 1'b1;
      endcase
    end
  end

  always @(negedge clk_i) if (rst_done && done_o) done_cnt++;

  // monitor / scoreboard, one sample per memory cycle
  int  ms = 0, gap = 0, beats = 0;
  bit  prev_cs = 1, prev2_cs = 1, held = 0;
  rq_t cur;
  always @(negedge clk_i) begin
    if (rst_done && mem_clk_o) begin
      chk(mem_oe_n_o == 1'b1, "R8", "oe_n", mem_oe_n_o, 1);
      if (mem_cs_n_o)
        chk(!mem_ad_oe_o && mem_we_n_o && mem_adv_n_o && mem_bl_n_o == 2'b11, "R1",
            "idle pins", {mem_ad_oe_o, mem_we_n_o, mem_adv_n_o, mem_bl_n_o}, 5'b01111);
      case (ms)
        0: if (!mem_adv_n_o) begin
          chk(!prev_cs && prev2_cs, "R3", "cs lead", {prev2_cs, prev_cs}, 2'b10);
          if (rq_q.size() == 0) chk(0, "R4", "unexpected address phase", 1, 0);
          else begin
            cur = rq_q.pop_front();
            chk(mem_ad_o == cur.a[15:0], "R4", "low addr", mem_ad_o, cur.a[15:0]);
            chk(mem_ahi_o == cur.a[25:16], "R4", "high addr", mem_ahi_o, cur.a[25:16]);
            chk(!mem_we_n_o, "R8", "we in addr", mem_we_n_o, 0);
            gap = 0; beats = 0; held = 0; ms = 1;
          end
        end
        1, 2: begin
          chk(mem_ahi_o == cur.a[25:16], "R4", "high addr held", mem_ahi_o, cur.a[25:16]);
          if (ms == 1 && !mem_ad_oe_o) begin
            gap++;
            chk(!mem_we_n_o && mem_adv_n_o, "R5", "latency pins",
                {mem_we_n_o, mem_adv_n_o}, 2'b01);
          end else begin
            if (ms == 1) chk(gap == cur.lat + 1, "R5", "latency", gap, cur.lat + 1);
            chk(mem_ad_oe_o && mem_adv_n_o && !mem_we_n_o, "R6", "beat pins",
                {mem_ad_oe_o, mem_adv_n_o, mem_we_n_o}, 3'b110);
            if (exp_q.size() == 0) chk(0, "R6", "extra beat", 1, 0);
            else begin
              chk(mem_ad_o == exp_q[0].w, held ? "R7" : "R6", "beat data", mem_ad_o, exp_q[0].w);
              chk(mem_bl_n_o == ~exp_q[0].be, held ? "R7" : "R6", "byte lanes",
                  mem_bl_n_o, ~exp_q[0].be);
              if (mem_wait_n_i) begin
                void'(exp_q.pop_front());
                beats++; held = 0;
                if (beats == cur.len) begin
                  chk(done_o, "R10", "done on last", done_o, 1);
                  ms = 3;
                end else begin
                  chk(!done_o, "R10", "early done", done_o, 0);
                  ms = 2;
                end
              end else begin
                chk(!done_o, "R7", "done while waiting", done_o, 0);
                held = 1; ms = 2;
              end
            end
          end
        end
        3: begin
          chk(!mem_cs_n_o && !mem_ad_oe_o && mem_we_n_o, "R9", "tail cycle",
              {mem_cs_n_o, mem_ad_oe_o, mem_we_n_o}, 3'b001);
          ms = 4;
        end
        4: begin
          chk(mem_cs_n_o, "R9", "cs release", mem_cs_n_o, 1);
          ms = 0;
        end
        default: ms = 0;
      endcase
      prev2_cs = prev_cs;
      prev_cs  = mem_cs_n_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; req_valid_i = 1'b0; req_addr_i = '0; req_len_i = '0;
    cfg_lat_i = '0; mem_wait_n_i = 1'b1; wr_data_i = '0; wr_be_i = '0;
    repeat (3) @(negedge clk_i);
    chk(mem_cs_n_o && mem_adv_n_o && mem_we_n_o && mem_oe_n_o && mem_bl_n_o == 2'b11,
        "R1", "reset strobes", {mem_cs_n_o, mem_adv_n_o, mem_we_n_o, mem_oe_n_o, mem_bl_n_o},
        6'b111111);
    chk(!mem_ad_oe_o && !mem_clk_o && !done_o && !req_ready_o, "R1", "reset bus/clk",
        {mem_ad_oe_o, mem_clk_o, done_o, req_ready_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 6; i++) begin
      logic p;
      p = mem_clk_o;
      @(negedge clk_i);
      chk(mem_clk_o != p, "R2", "memory clock toggle", mem_clk_o, ~p);
    end
    rst_done = 1;

    wait_mode = 0;
    send(26'h2A5_1234, 4, 0);
    send(26'h3FF_FFFF, 1, 3);
    send(26'h001_8001, 16, 15);
    wait_mode = 1;
    send(26'h0C3_5A5A, 5, 2);
    send(26'h155_AAAA, 1, 0);
    wait_mode = 2;
    send(26'h2F0_0F0F, 3, 1);
    send(26'h000_0000, 16, 0);

    while (rq_q.size() != 0 || exp_q.size() != 0 || ms != 0) @(negedge clk_i);
    repeat (10) @(negedge clk_i);
    chk(done_cnt == bursts, "R10", "done pulses per burst", done_cnt, bursts);
    chk(feed_q.size() == 0, "R6", "words taken", feed_q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule